// File: doc/BRIEF.md
# Rotate, Shift and Single-Bit Unit

This block is the combinational datapath slice that serves an 8-bit processor's rotate, shift, nibble-rotate and single-bit instructions. One operand byte comes in together with the accumulator, the current flag byte, a 3-bit bit index and a 4-bit operation code. In the same cycle the block returns a result byte for the operand's destination, an updated accumulator and an updated flag byte. Fetching and storing the operand, and working out its address, are left to the surrounding core.

The unit has no storage and no sequencing. Its single "state" is the operation class that the decoder derives from the code: general rotate/shift, accumulator rotate, nibble rotate, bit test or bit modify. Each class selects a result path and a flag-update rule. The transitions are the code changes on `op_i` from one cycle to the next. Every code takes effect without delay, and no code depends on an earlier one.

The flag byte layout is S=bit 7, Z=bit 6, H=bit 4, P/V=bit 2, N=bit 1, C=bit 0. Bits 5 and 3 pass through unchanged. Operation codes: 0 rotate left circular, 1 rotate right circular, 2 rotate left through carry, 3 rotate right through carry, 4 arithmetic shift left, 5 arithmetic shift right, 6 logical shift right, 7–10 the accumulator forms of codes 0–3 in the same order, 11 nibble rotate left, 12 nibble rotate right, 13 bit test, 14 bit set, 15 bit reset.

Top module: `rsb_unit`

## Requirements
- R1: For codes 0–3, `res_o` is the operand rotated by one place. Circular rotates copy the bit that leaves the byte into both the vacated end and C. Through-carry rotates treat {C, operand} as a 9-bit ring.
- R2: Code 4 doubles the operand (bit 7 to C, 0 into bit 0). Code 5 shifts right and keeps bit 7 (bit 0 to C). Code 6 shifts right with 0 into bit 7 and bit 0 to C.
- R3: For codes 0–6, S is result bit 7 and Z is 1 exactly when the result is zero. P is 1 when the result holds an even number of ones. H and N are 0.
- R4: Codes 7–10 apply the rotate of codes 0–3 to `acc_i` and return it on `acc_o`, with `res_o` equal to the operand. S, Z and P are kept, H and N are cleared and C is updated.
- R5: Code 11 gives `res_o` = {operand[3:0], acc[3:0]} and `acc_o` = {acc[7:4], operand[7:4]}.
- R6: Code 12 gives `res_o` = {acc[3:0], operand[7:4]} and `acc_o` = {acc[7:4], operand[3:0]}.
- R7: For codes 11–12, S, Z and P (even parity) come from the new accumulator, H and N are 0 and C is kept. The accumulator high nibble is never changed.
- R8: Code 13 sets Z to 1 when operand bit `bit_sel_i` is 0 and to 0 otherwise. It sets H to 1, clears N and keeps S, P and C. `res_o` equals the operand.
- R9: Code 14 forces the selected operand bit to 1 and code 15 forces it to 0; all other bits and the whole flag byte are unchanged.
- R10: Flag bits 5 and 3 always equal their inputs. `acc_o` equals `acc_i` for every code other than 7–12.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opd_i | input | 8 | Operand byte |
| acc_i | input | 8 | Accumulator in |
| flags_i | input | 8 | Flag byte in |
| bit_sel_i | input | 3 | Bit index for codes 13–15 |
| op_i | input | 4 | Operation code |
| res_o | output | 8 | Result byte for the operand destination |
| acc_o | output | 8 | Updated accumulator |
| flags_o | output | 8 | Updated flag byte |

## Verification
The assertions are immediate checks evaluated whenever the combinational outputs settle. They assume every input is a known value and that all inputs change together, so that the outputs are never read while half of an input set has been applied. The stimulus keeps to this: one task drives every input at the same moment, away from the clock edge, and results are compared half a period later. Because all sixteen codes are defined, the stimulus sweeps every code with directed corner values (all zeros, all ones, single bits, carry in both states) and then with pseudo-random bytes.

// File: rtl/rsb_pkg.sv
package rsb_pkg;

    localparam int DATA_W = 8;
    localparam int NIB_W  = DATA_W / 2;
    localparam int IDX_W  = $clog2(DATA_W);

    // flag byte positions (the surrounding core decodes these)
    localparam int FL_S = 7;
    localparam int FL_Z = 6;
    localparam int FL_H = 4;
    localparam int FL_P = 2;
    localparam int FL_N = 1;
    localparam int FL_C = 0;

    typedef enum logic [3:0] {
        OP_RLC  = 4'd0,
        OP_RRC  = 4'd1,
        OP_RL   = 4'd2,
        OP_RR   = 4'd3,
        OP_SLA  = 4'd4,
        OP_SRA  = 4'd5,
        OP_SRL  = 4'd6,
        OP_RLCA = 4'd7,
        OP_RRCA = 4'd8,
        OP_RLA  = 4'd9,
        OP_RRA  = 4'd10,
        OP_NRL  = 4'd11,
        OP_NRR  = 4'd12,
        OP_BTST = 4'd13,
        OP_BSET = 4'd14,
        OP_BCLR = 4'd15
    } rsb_op_e;

    // operation class: selects the result path and flag rule
    typedef enum logic [2:0] {
        CL_GEN,
        CL_ACC,
        CL_NIB,
        CL_TST,
        CL_MOD
    } rsb_class_e;

    function automatic rsb_class_e op_class(rsb_op_e op);
        rsb_class_e c;
        unique case (op)
            OP_RLC, OP_RRC, OP_RL, OP_RR,
            OP_SLA, OP_SRA, OP_SRL:         c = CL_GEN;
            OP_RLCA, OP_RRCA, OP_RLA, OP_RRA: c = CL_ACC;
            OP_NRL, OP_NRR:                 c = CL_NIB;
            OP_BTST:                        c = CL_TST;
            default:                        c = CL_MOD;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/rsb_shift_core.sv
module rsb_shift_core
    import rsb_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic [W-1:0] val_i,
    input  logic         cin_i,
    input  rsb_op_e      op_i,
    output logic [W-1:0] val_o,
    output logic         cout_o
);

    always_comb begin
        val_o  = val_i;
        cout_o = cin_i;
        unique case (op_i)
            OP_RLC, OP_RLCA: begin
                val_o  = {val_i[W-2:0], val_i[W-1]};
                cout_o = val_i[W-1];
            end
            OP_RRC, OP_RRCA: begin
                val_o  = {val_i[0], val_i[W-1:1]};
                cout_o = val_i[0];
            end
            OP_RL, OP_RLA: begin
                val_o  = {val_i[W-2:0], cin_i};
                cout_o = val_i[W-1];
            end
            OP_RR, OP_RRA: begin
                val_o  = {cin_i, val_i[W-1:1]};
                cout_o = val_i[0];
            end
            OP_SLA: begin
                val_o  = {val_i[W-2:0], 1'b0};
                cout_o = val_i[W-1];
            end
            OP_SRA: begin
                val_o  = {val_i[W-1], val_i[W-1:1]};
                cout_o = val_i[0];
            end
            OP_SRL: begin
                val_o  = {1'b0, val_i[W-1:1]};
                cout_o = val_i[0];
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/rsb_nibble_rot.sv
module rsb_nibble_rot
    import rsb_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic [W-1:0] mem_i,
    input  logic [W-1:0] acc_i,
    input  logic         right_i,
    output logic [W-1:0] mem_o,
    output logic [W-1:0] acc_o
);

    localparam int H = W / 2;

    logic [H-1:0] m_hi, m_lo, a_lo;

    assign m_hi = mem_i[W-1:H];
    assign m_lo = mem_i[H-1:0];
    assign a_lo = acc_i[H-1:0];

    // 3-nibble ring: {acc_lo, mem_hi, mem_lo}
    always_comb begin
        if (right_i) begin
            mem_o = {a_lo, m_hi};
            acc_o = {acc_i[W-1:H], m_lo};
        end else begin
            mem_o = {m_lo, a_lo};
            acc_o = {acc_i[W-1:H], m_hi};
        end
    end

endmodule

// File: rtl/rsb_bit_core.sv
module rsb_bit_core
    import rsb_pkg::*;
#(
    parameter int W  = DATA_W,
    parameter int IW = IDX_W
) (
    input  logic [W-1:0]  val_i,
    input  logic [IW-1:0] idx_i,
    input  logic          set_i,
    input  logic          clr_i,
    output logic [W-1:0]  val_o,
    output logic          bit_o
);

    for (genvar g = 0; g < W; g++) begin : g_lane
        logic hit;
        assign hit = (idx_i == IW'(g));
        assign val_o[g] = hit ? ((val_i[g] | set_i) & ~clr_i) : val_i[g];
    end

    assign bit_o = val_i[idx_i];

endmodule

// File: rtl/rsb_unit.sv
module rsb_unit
    import rsb_pkg::*;
(
    input  logic [7:0] opd_i,
    input  logic [7:0] acc_i,
    input  logic [7:0] flags_i,
    input  logic [2:0] bit_sel_i,
    input  logic [3:0] op_i,
    output logic [7:0] res_o,
    output logic [7:0] acc_o,
    output logic [7:0] flags_o
);

    rsb_op_e    op;
    rsb_class_e cls;

    assign op  = rsb_op_e'(op_i);
    assign cls = op_class(op);

    logic [DATA_W-1:0] sh_in, sh_out, nb_mem, nb_acc, bt_out;
    logic              sh_cout, bt_bit;

    assign sh_in = (cls == CL_ACC) ? acc_i : opd_i;

    rsb_shift_core #(.W(DATA_W)) u_shift (
        .val_i  (sh_in),
        .cin_i  (flags_i[FL_C]),
        .op_i   (op),
        .val_o  (sh_out),
        .cout_o (sh_cout)
    );

    rsb_nibble_rot #(.W(DATA_W)) u_nib (
        .mem_i   (opd_i),
        .acc_i   (acc_i),
        .right_i (op == OP_NRR),
        .mem_o   (nb_mem),
        .acc_o   (nb_acc)
    );

    rsb_bit_core #(.W(DATA_W), .IW(IDX_W)) u_bit (
        .val_i (opd_i),
        .idx_i (bit_sel_i),
        .set_i (op == OP_BSET),
        .clr_i (op == OP_BCLR),
        .val_o (bt_out),
        .bit_o (bt_bit)
    );

    // data outputs
    always_comb begin
        res_o = opd_i;
        acc_o = acc_i;
        unique case (cls)
            CL_GEN: res_o = sh_out;
            CL_ACC: acc_o = sh_out;
            CL_NIB: begin
                res_o = nb_mem;
                acc_o = nb_acc;
            end
            CL_TST: ;
            CL_MOD: res_o = bt_out;
        endcase
    end

    // flag outputs
    always_comb begin
        flags_o = flags_i;
        unique case (cls)
            CL_GEN: begin
                flags_o[FL_S] = sh_out[DATA_W-1];
                flags_o[FL_Z] = (sh_out == '0);
                flags_o[FL_H] = 1'b0;
                flags_o[FL_P] = ~^sh_out;
                flags_o[FL_N] = 1'b0;
                flags_o[FL_C] = sh_cout;
            end
            CL_ACC: begin
                flags_o[FL_H] = 1'b0;
                flags_o[FL_N] = 1'b0;
                flags_o[FL_C] = sh_cout;
            end
            CL_NIB: begin
                flags_o[FL_S] = nb_acc[DATA_W-1];
                flags_o[FL_Z] = (nb_acc == '0);
                flags_o[FL_H] = 1'b0;
                flags_o[FL_P] = ~^nb_acc;
                flags_o[FL_N] = 1'b0;
            end
            CL_TST: begin
                flags_o[FL_Z] = ~bt_bit;
                flags_o[FL_H] = 1'b1;
                flags_o[FL_N] = 1'b0;
            end
            CL_MOD: ;
        endcase
    end

endmodule

// File: rtl/rsb_unit_chk.sv
module rsb_unit_chk
    import rsb_pkg::*;
(
    input logic [7:0] opd_i,
    input logic [7:0] acc_i,
    input logic [7:0] flags_i,
    input logic [3:0] op_i,
    input logic [7:0] res_o,
    input logic [7:0] acc_o,
    input logic [7:0] flags_o
);

    always_comb begin
        if (op_i == OP_RLC || op_i == OP_RRC) begin
            assert_circ_keeps_ones_R1: assert ($countones(res_o) == $countones(opd_i))
                else $error("circular rotate changed the count of ones");
        end
        if (op_i <= OP_SRL) begin
            assert_gen_flags_R3: assert (!flags_o[FL_H] && !flags_o[FL_N] && (flags_o[FL_Z] == (res_o == 8'h00)))
                else $error("general rotate/shift flag rule broken");
        end
        if (op_i >= OP_RLCA && op_i <= OP_RRA) begin
            assert_acc_keeps_szp_R4: assert (flags_o[FL_S] == flags_i[FL_S] && flags_o[FL_Z] == flags_i[FL_Z] && flags_o[FL_P] == flags_i[FL_P] && res_o == opd_i)
                else $error("accumulator rotate disturbed S/Z/P or result");
        end
        if (op_i == OP_NRL || op_i == OP_NRR) begin
            assert_nib_acc_hi_R7: assert (acc_o[7:4] == acc_i[7:4] && flags_o[FL_C] == flags_i[FL_C])
                else $error("nibble rotate touched acc high nibble or carry");
        end
        if (op_i == OP_BTST) begin
            assert_btst_flags_R8: assert (flags_o[FL_H] && !flags_o[FL_N] && flags_o[FL_C] == flags_i[FL_C] && res_o == opd_i)
                else $error("bit test flag rule broken");
        end
        if (op_i == OP_BSET || op_i == OP_BCLR) begin
            assert_bmod_one_bit_R9: assert (flags_o == flags_i && $countones(res_o ^ opd_i) <= 1)
                else $error("bit set/reset changed flags or more than one bit");
        end
        assert_spare_flags_R10: assert (flags_o[5] == flags_i[5] && flags_o[3] == flags_i[3])
            else $error("spare flag bits changed");
    end

endmodule

bind rsb_unit rsb_unit_chk u_chk (
    .opd_i   (opd_i),
    .acc_i   (acc_i),
    .flags_i (flags_i),
    .op_i    (op_i),
    .res_o   (res_o),
    .acc_o   (acc_o),
    .flags_o (flags_o)
);

// File: tb/rsb_unit_bench.sv
module rsb_unit_bench;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] opd, acc, fl;
    logic [2:0] bsel;
    logic [3:0] op;
    logic [7:0] res_w, acc_w, fl_w;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rsb_unit u_rsb_unit (
        .opd_i     (opd),
        .acc_i     (acc),
        .flags_i   (fl),
        .bit_sel_i (bsel),
        .op_i      (op),
        .res_o     (res_w),
        .acc_o     (acc_w),
        .flags_o   (fl_w)
    );

    function automatic int ones(input int v);
        int n = 0;
        for (int i = 0; i < 8; i++) n += (v >> i) & 1;
        return n;
    endfunction

    // behavioural reference: integers only
    task automatic model(input int o, input int v, input int a, input int f, input int b,
                         output int r, output int ao, output int fo);
        int c, t, nc, x;
        c  = f & 1;
        r  = v;
        ao = a;
        fo = f;
        nc = c;
        x  = v;
        if (o >= 7 && o <= 10) x = a;
        case (o)
            0, 7:  begin t = x * 2 + (x / 128); nc = x / 128; end
            1, 8:  begin t = x / 2 + (x % 2) * 128; nc = x % 2; end
            2, 9:  begin t = x * 2 + c; nc = x / 128; end
            3, 10: begin t = c * 256 + x; nc = t % 2; t = t / 2; end
            4:     begin t = x * 2; nc = x / 128; end
            5:     begin t = x / 2 + (x & 128); nc = x % 2; end
            6:     begin t = x / 2; nc = x % 2; end
            default: t = 0;
        endcase
        t = t % 256;
        if (o <= 6) begin
            r  = t;
            fo = f & 8'h28;
            if (t >= 128) fo += 128;
            if (t == 0) fo += 64;
            if (ones(t) % 2 == 0) fo += 4;
            fo += nc;
        end else if (o <= 10) begin
            ao = t;
            fo = (f & 8'hC4) | (f & 8'h28) | nc;
        end else if (o <= 12) begin
            if (o == 11) begin
                r  = (v % 16) * 16 + (a % 16);
                ao = (a / 16) * 16 + v / 16;
            end else begin
                r  = (a % 16) * 16 + v / 16;
                ao = (a / 16) * 16 + (v % 16);
            end
            fo = (f & 8'h28) | (f & 1);
            if (ao >= 128) fo += 128;
            if (ao == 0) fo += 64;
            if (ones(ao) % 2 == 0) fo += 4;
        end else if (o == 13) begin
            fo = (f & 8'hAD) | 16;
            if (((v >> b) & 1) == 0) fo += 64;
        end else if (o == 14) begin
            r = v | (1 << b);
        end else begin
            r = v & ~(1 << b) & 255;
        end
    endtask

    function automatic string res_tag(input int o);
        if (o <= 3) return "R1";
        if (o <= 6) return "R2";
        if (o <= 10) return "R4";
        if (o == 11) return "R5";
        if (o == 12) return "R6";
        if (o == 13) return "R8";
        return "R9";
    endfunction

    function automatic string fl_tag(input int o);
        if (o <= 6) return "R3";
        if (o <= 10) return "R4";
        if (o <= 12) return "R7";
        if (o == 13) return "R8";
        return "R9";
    endfunction

    function automatic string acc_tag(input int o);
        if (o >= 7 && o <= 10) return "R4";
        if (o == 11) return "R5";
        if (o == 12) return "R6";
        return "R10";
    endfunction

    task automatic check(input string tag, input string what, input int o, input int got, input int exp);
        n_run++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s %s op=%0d actual=%02h expected=%02h", tag, what, o, got, exp);
        end
    endtask

    task automatic apply(input int o, input int v, input int a, input int f, input int b);
        int r, ao, fo;
        @(posedge clk);
        #1;
        op   = 4'(o);
        opd  = 8'(v);
        acc  = 8'(a);
        fl   = 8'(f);
        bsel = 3'(b);
        model(o, v, a, f, b, r, ao, fo);
        @(negedge clk);
        check(res_tag(o), "res", o, int'(res_w), r);
        check(acc_tag(o), "acc", o, int'(acc_w), ao);
        check(fl_tag(o), "flags", o, int'(fl_w), fo);
        check("R10", "spare flags", o, int'(fl_w & 8'h28), f & 8'h28);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        int cyc = 0;
        while (cyc < WATCHDOG) begin
            @(posedge clk);
            cyc++;
        end
        n_fail++;
        n_run++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        op = '0; opd = '0; acc = '0; fl = '0; bsel = '0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        // reset-state inputs: zero byte rotated gives Z and P set (R3)
        check("R3", "reset res", 0, int'(res_w), 0);
        check("R3", "reset flags", 0, int'(fl_w), 8'h44);

        // directed corners over every code
        for (int o = 0; o < 16; o++) begin
            apply(o, 8'h00, 8'h00, 8'h00, 0);
            apply(o, 8'hFF, 8'hFF, 8'hFF, 7);
            apply(o, 8'h80, 8'h01, 8'h01, 7);
            apply(o, 8'h01, 8'h80, 8'h00, 0);
            apply(o, 8'h81, 8'h5A, 8'hD7, 3);
            apply(o, 8'h12, 8'h34, 8'h28, 4);
        end
        // R5 / R6 named examples
        apply(11, 8'hAB, 8'h3C, 8'h00, 0);  // R5: res=BC acc=3A
        apply(12, 8'hAB, 8'h3C, 8'h01, 0);  // R6: res=CA acc=3B
        // R8: every bit index, bit clear and set
        for (int b = 0; b < 8; b++) begin
            apply(13, (1 << b), 8'h00, 8'h00, b);
            apply(13, ~(1 << b) & 255, 8'h00, 8'hFF, b);
        end
        // pseudo-random sweep
        for (int k = 0; k < 3000; k++) begin
            apply(k % 16, int'($urandom_range(0, 255)), int'($urandom_range(0, 255)),
                  int'($urandom_range(0, 255)), int'($urandom_range(0, 7)));
        end
        finish_run();
    end

endmodule